// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Check

This block steps a minimal accumulator machine through its instruction cycle. Each instruction passes through the same phases in order. A fetch phase presents the program counter to a single-port synchronous memory. A capture phase latches the returned word and advances the program counter. An execute phase then performs a data transfer, an arithmetic step or a change of control flow. Load and add take an extra cycle to collect their operand. Every instruction ends with an interrupt-check phase.

The interrupt-check phase handles interrupts entirely in hardware. If the single request line is high and interrupts are enabled, it pushes the program counter and accumulator onto a small internal context stack. It then clears the enable and redirects the program counter to a fixed handler address, pulsing an acknowledge output for one cycle. A return instruction pops the stack and re-enables interrupts, so the interrupted program resumes where it stopped. A dedicated enable instruction lets software open the machine to interrupts, including nested ones inside a handler, up to the depth of the stack.

Top module: `instr_cycle_seq`

## Requirements
- R1: While the synchronous active-high reset is applied, the program counter and accumulator read 0, the interrupt enable reads 0, the write strobe and the acknowledge are low, and the memory address reads 0. The first fetch after release therefore comes from address 0.
- R2: Instruction words are 16 bits: the opcode is bits [15:12] and the operand address is bits [11:0]. In the fetch cycle the memory address equals the program counter. The word is captured one cycle later, at which point the program counter is incremented by one.
- R3: Opcode 0 (load) places the memory word at the operand address into the accumulator. The instruction takes 5 cycles in total.
- R4: Opcode 1 (store) raises the write strobe for exactly one cycle, in the third cycle of the instruction. During that cycle the memory address is the operand address and the write data equals the accumulator. The instruction takes 4 cycles.
- R5: Opcode 2 (add) adds the memory word at the operand address to the accumulator, wrapping modulo 2^16. The instruction takes 5 cycles.
- R6: Opcode 3 (jump) replaces the program counter with the operand address. The instruction takes 4 cycles.
- R7: Opcode 5 sets the interrupt enable. Opcodes 6 to 15 change nothing except advancing the program counter. Both take 4 cycles.
- R8: A request seen while the interrupt enable is 0 is ignored: the program counter continues in sequence and no acknowledge occurs.
- R9: When the request is high and interrupts are enabled in the check phase, the sequencer does four things. It saves the program counter and accumulator, loads the program counter with the handler address (parameter, default 12'h100) and clears the enable. It also raises the acknowledge for exactly one cycle, which is the next fetch cycle.
- R10: Opcode 4 (return) pops the most recent saved context into the program counter and accumulator and sets the interrupt enable.
- R11: The context stack holds SAVE_DEPTH entries (default 2). When it is full, a pending enabled request is not taken and the sequencer falls through to the next fetch.
- R12: A return executed with an empty context stack leaves the program counter and accumulator as they are and only sets the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Registered memory address |
| mem_wdata | output | 16 | Registered memory write data |
| mem_we | output | 1 | Registered memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| irq | input | 1 | Combined interrupt request |
| irq_ack | output | 1 | One-cycle pulse when the handler is entered |
| cur_pc | output | 12 | Program counter |
| accum | output | 16 | Accumulator |
| int_enable | output | 1 | Interrupt enable flag |

## Verification
The instruction word is captured one cycle after the fetch cycle, and the program counter moves at that same edge. The store strobe appears two cycles after the fetch cycle. A load or add result reaches the accumulator four cycles after fetch, because the operand read costs one extra cycle. The acknowledge and the handler address appear together in the fetch cycle that follows the check phase. The bench steps its own phase-counted model on every rising edge and compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. After the run, the memory contents written by the stores are compared against the model.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_LOADIR,
    PH_EXEC,
    PH_MEMRD,
    PH_CHECK
  } phase_t;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_ADD   = 4'd2,
    OP_JUMP  = 4'd3,
    OP_RETI  = 4'd4,
    OP_ENINT = 4'd5
  } opcode_t;

  typedef struct packed {
    logic is_load;
    logic is_store;
    logic is_add;
    logic is_jump;
    logic is_reti;
    logic is_enint;
  } dec_t;
endpackage

// File: rtl/ics_decode.sv
module ics_decode
  import ics_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);
  always_comb begin
    dec          = '0;
    dec.is_load  = (opc == OP_LOAD);
    dec.is_store = (opc == OP_STORE);
    dec.is_add   = (opc == OP_ADD);
    dec.is_jump  = (opc == OP_JUMP);
    dec.is_reti  = (opc == OP_RETI);
    dec.is_enint = (opc == OP_ENINT);
  end
endmodule

// File: rtl/ics_ctx_stack.sv
module ics_ctx_stack #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] top_data,
  output logic             full,
  output logic             empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slot [DEPTH];
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign wr_idx = IDX_W'(count);
  assign rd_idx = IDX_W'(count - CNT_W'(1));
  assign top_data = empty ? '0 : slot[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + CNT_W'(1);
    end else if (pop && !empty) begin
      count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) slot[wr_idx] <= push_data;
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import ics_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int VECTOR     = 'h100,
  parameter int SAVE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [OPC_W+ADDR_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [OPC_W+ADDR_W-1:0] mem_rdata,
  input  logic              irq,
  output logic              irq_ack,
  output logic [ADDR_W-1:0] cur_pc,
  output logic [OPC_W+ADDR_W-1:0] accum,
  output logic              int_enable
);
  localparam int DATA_W = OPC_W + ADDR_W;
  localparam int CTX_W  = ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] VEC_A = ADDR_W'(VECTOR);

  phase_t            phase;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic              ien_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0] mwd_q;
  logic              mwe_q;
  logic              ack_q;

  logic [OPC_W-1:0]  opc_sel;
  dec_t              dec;
  logic              take_irq;
  logic              do_pop;
  logic              stk_full;
  logic              stk_empty;
  logic [CTX_W-1:0]  ctx_top;

  // Decode the word arriving from memory during capture, the held word later on.
  assign opc_sel = (phase == PH_LOADIR) ? mem_rdata[DATA_W-1 -: OPC_W]
                                        : ir_q[DATA_W-1 -: OPC_W];

  ics_decode u_dec (
    .opc (opc_sel),
    .dec (dec)
  );

  assign take_irq = (phase == PH_CHECK) && irq && ien_q && !stk_full;
  assign do_pop   = (phase == PH_EXEC) && dec.is_reti;

  ics_ctx_stack #(
    .DEPTH (SAVE_DEPTH),
    .WIDTH (CTX_W)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (take_irq),
    .pop       (do_pop),
    .push_data ({pc_q, acc_q}),
    .top_data  (ctx_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      ien_q   <= 1'b0;
      maddr_q <= '0;
      mwd_q   <= '0;
      mwe_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      mwe_q <= 1'b0;
      ack_q <= 1'b0;
      unique case (phase)
        PH_FETCH: phase <= PH_LOADIR;
        PH_LOADIR: begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + ADDR_W'(1);
          if (dec.is_load || dec.is_add || dec.is_store)
            maddr_q <= mem_rdata[ADDR_W-1:0];
          if (dec.is_store) begin
            mwe_q <= 1'b1;
            mwd_q <= acc_q;
          end
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (dec.is_jump) pc_q <= ir_q[ADDR_W-1:0];
          if (dec.is_reti) begin
            ien_q <= 1'b1;
            if (!stk_empty) {pc_q, acc_q} <= ctx_top;
          end
          if (dec.is_enint) ien_q <= 1'b1;
          phase <= (dec.is_load || dec.is_add) ? PH_MEMRD : PH_CHECK;
        end
        PH_MEMRD: begin
          acc_q <= dec.is_load ? mem_rdata : acc_q + mem_rdata;
          phase <= PH_CHECK;
        end
        PH_CHECK: begin
          if (take_irq) begin
            pc_q    <= VEC_A;
            ien_q   <= 1'b0;
            ack_q   <= 1'b1;
            maddr_q <= VEC_A;
          end else begin
            maddr_q <= pc_q;
          end
          phase <= PH_FETCH;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  assign mem_addr   = maddr_q;
  assign mem_wdata  = mwd_q;
  assign mem_we     = mwe_q;
  assign irq_ack    = ack_q;
  assign cur_pc     = pc_q;
  assign accum      = acc_q;
  assign int_enable = ien_q;
endmodule

// File: rtl/ics_checker.sv
module ics_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int VECTOR = 'h100
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              irq,
  input logic              irq_ack,
  input logic [ADDR_W-1:0] cur_pc,
  input logic [DATA_W-1:0] accum,
  input logic              int_enable
);
  // R9: acknowledge lasts one cycle
  a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  // R9: acknowledge arrives with the handler address and a cleared enable
  a_r9_ack_vectored: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (!int_enable && cur_pc == ADDR_W'(VECTOR) && mem_addr == ADDR_W'(VECTOR)));

  // R8: no acknowledge unless the request was seen with the enable set
  a_r8_ack_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> ($past(irq) && $past(int_enable)));

  // R4: write strobe lasts one cycle
  a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4: stored data equals the accumulator and the accumulator holds
  a_r4_we_data: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == accum) ##1 $stable(accum));
endmodule

bind instr_cycle_seq ics_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (OPC_W + ADDR_W),
  .VECTOR (VECTOR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_we     (mem_we),
  .irq        (irq),
  .irq_ack    (irq_ack),
  .cur_pc     (cur_pc),
  .accum      (accum),
  .int_enable (int_enable)
);

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int VEC = 'h100;
  localparam int DEPTH = 2;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata = '0;
  logic          irq_ack;
  logic [AW-1:0] cur_pc;
  logic [DW-1:0] accum;
  logic          int_enable;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  instr_cycle_seq #(.ADDR_W(AW), .VECTOR(VEC), .SAVE_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .irq(irq), .irq_ack(irq_ack),
    .cur_pc(cur_pc), .accum(accum), .int_enable(int_enable)
  );

  // Bench memory seen by the design, and a shadow copy owned by the model.
  logic [DW-1:0] mem  [MEMN];
  logic [DW-1:0] smem [MEMN];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // Behavioural reference: phase counter 0 fetch, 1 capture, 2 execute, 3 operand, 4 check.
  int            m_ph;
  logic [AW-1:0] m_pc, m_addr, m_opnd;
  logic [DW-1:0] m_acc, m_wd;
  logic          m_ien, m_we, m_ack;
  int            m_op;
  logic [AW+DW-1:0] ctxq[$];
  int            m_acks, d_acks, m_refused;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_pc = '0; m_addr = '0; m_acc = '0; m_wd = '0;
      m_ien = 0; m_we = 0; m_ack = 0; m_op = 0; m_opnd = '0;
      ctxq.delete();
    end else begin
      m_we = 0; m_ack = 0;
      case (m_ph)
        0: m_ph = 1;
        1: begin
          m_op   = int'(smem[m_pc][15:12]);
          m_opnd = smem[m_pc][11:0];
          m_pc   = m_pc + 1;
          if (m_op <= 2) m_addr = m_opnd;
          if (m_op == 1) begin m_we = 1; m_wd = m_acc; end
          m_ph = 2;
        end
        2: begin
          if (m_op == 1) smem[m_opnd] = m_acc;
          if (m_op == 3) m_pc = m_opnd;
          if (m_op == 4) begin
            if (ctxq.size() > 0) {m_pc, m_acc} = ctxq.pop_back();
            m_ien = 1;
          end
          if (m_op == 5) m_ien = 1;
          m_ph = (m_op == 0 || m_op == 2) ? 3 : 4;
        end
        3: begin
          if (m_op == 0) m_acc = smem[m_opnd];
          else m_acc = m_acc + smem[m_opnd];
          m_ph = 4;
        end
        default: begin
          if (irq && m_ien && ctxq.size() < DEPTH) begin
            ctxq.push_back({m_pc, m_acc});
            m_pc = AW'(VEC); m_ien = 0; m_ack = 1; m_acks++;
          end else if (irq && m_ien) begin
            m_refused++;
          end
          m_addr = m_pc;
          m_ph = 0;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every output on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(mem_addr == m_addr, "R2", "mem_addr", mem_addr, m_addr);
      check(mem_we == m_we, "R4", "mem_we", mem_we, m_we);
      if (m_we) check(mem_wdata == m_wd, "R4", "mem_wdata", mem_wdata, m_wd);
      check(cur_pc == m_pc, "R6 R9 R10 R11", "cur_pc", cur_pc, m_pc);
      check(accum == m_acc, "R3 R5 R10", "accum", accum, m_acc);
      check(int_enable == m_ien, "R7 R10 R12", "int_enable", int_enable, m_ien);
      check(irq_ack == m_ack, "R9", "irq_ack", irq_ack, m_ack);
      if (irq_ack) d_acks++;
    end
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_acks = 0; d_acks = 0; m_refused = 0;
    for (int i = 0; i < MEMN; i++) begin mem[i] = '0; smem[i] = '0; end
    // Main program
    mem[12'h000] = 16'h6000;  // no-op while request is high and enable is 0 (R8)
    mem[12'h001] = 16'h5000;  // enable interrupts (R7)
    mem[12'h002] = 16'h0200;  // load (R3)
    mem[12'h003] = 16'h2201;  // add with wrap (R5)
    mem[12'h004] = 16'h1202;  // store (R4)
    mem[12'h005] = 16'h4000;  // return with empty stack (R12)
    mem[12'h006] = 16'h3010;  // jump (R6)
    mem[12'h010] = 16'h2201;
    mem[12'h011] = 16'hF000;
    mem[12'h012] = 16'h3010;
    // Handler
    mem[12'h100] = 16'h5000;  // re-enable for nesting (R11)
    mem[12'h101] = 16'h0203;
    mem[12'h102] = 16'h1204;
    mem[12'h103] = 16'hF000;
    mem[12'h104] = 16'h4000;  // return (R10)
    mem[12'h200] = 16'h0005;
    mem[12'h201] = 16'hFFFE;
    mem[12'h203] = 16'h1234;
    for (int i = 0; i < MEMN; i++) smem[i] = mem[i];

    irq = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cur_pc == 0 && accum == 0, "R1", "pc/acc in reset", {cur_pc, accum}, 0);
    check(!int_enable && !mem_we && !irq_ack, "R1", "flags in reset",
          {int_enable, mem_we, irq_ack}, 0);
    check(mem_addr == 0, "R1", "mem_addr in reset", mem_addr, 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    irq = 1'b0;
    // R8: the request during the first no-op was refused
    check(d_acks == 0, "R8", "ack while disabled", d_acks, 0);
    check(cur_pc == 2, "R8", "pc after ignored request", cur_pc, 2);
    repeat (60) @(negedge clk);
    irq = 1'b1;
    repeat (120) @(negedge clk);
    irq = 1'b0;
    repeat (300) @(negedge clk);
    done = 1'b1;
    check(mem[12'h202] == 16'h0003, "R5", "wrapped sum stored", mem[12'h202], 16'h0003);
    check(mem[12'h204] == 16'h1234, "R4", "handler store", mem[12'h204], 16'h1234);
    check(d_acks == m_acks && m_acks >= 3, "R9", "acknowledge count", d_acks, m_acks);
    check(m_refused > 0, "R11", "full-stack refusals exercised", m_refused, 1);
    for (int a = 'h200; a < 'h210; a++)
      check(mem[a] == smem[a], "R4", "data memory", mem[a], smem[a]);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule